// File: doc/BRIEF.md
# Banked Output Mapper for Extended-Address Slaves

This block turns the information bits of an accepted master call into levels on four data output ports. It serves a slave that runs with extended addressing. In that mode the top information bit tells an A slave from a B slave at the same address, so only three bits of each call carry output data. The block never uses that top bit.

Two static configuration flags choose how the remaining bits reach the ports. With quad-output operation off, the three low bits drive the three low ports directly. With quad-output operation on, the bank-select bit picks one of two 2-bit banks, and the two lowest bits carry that bank's data. A master that wants all four outputs sends calls with the select bit alternating. The second flag, parallel update, makes the block keep the upper-bank data in a shadow register. The block then changes all four ports at once, on the next call that addresses the lower bank. Each output event raises a data strobe for one cycle. Telegram decoding, address matching and the slave's input response are handled elsewhere.

Calls arrive on a valid/ready pair. One call is taken on each rising edge where both signals are high. Ready is low during reset and high from the first clock edge after reset. The block never back-pressures, so a call source may hold valid for consecutive cycles to present back-to-back calls.

Top module: `bank_out_map`

## Requirements
- R1: While reset is asserted and after it is released, `data_out` is 0, `data_strobe` is 0 and the shadow bank holds 0. `call_ready` is 0 during reset.
- R2: `call_ready` is 1 from the first clock edge after reset on. A cycle without an accepted call leaves `data_out` unchanged and gives `data_strobe` = 0 in the next cycle.
- R3: With `quad_en` = 0, an accepted call loads `data_out[2:0]` from `call_info[2:0]`, and `data_out[3]` keeps its value. `par_en` has no effect in this mode.
- R4: With `quad_en` = 1 and `par_en` = 0, a call with `call_info[2]` = 0 loads `data_out[1:0]` from `call_info[1:0]`, and `data_out[3:2]` keeps its value.
- R5: With `quad_en` = 1 and `par_en` = 0, a call with `call_info[2]` = 1 loads `data_out[3:2]` from `call_info[1:0]`, and `data_out[1:0]` keeps its value.
- R6: Every output event drives `data_strobe` high for exactly the one cycle that follows the accepting edge. In the mode of R3 and the mode of R4/R5, every accepted call is an output event.
- R7: With `quad_en` = 1 and `par_en` = 1, a call with `call_info[2]` = 1 stores `call_info[1:0]` in the shadow bank. It leaves `data_out` unchanged and raises no strobe.
- R8: With `quad_en` = 1 and `par_en` = 1, a call with `call_info[2]` = 0 loads `data_out[1:0]` from `call_info[1:0]` and loads `data_out[3:2]` from the shadow bank on the same edge. It is an output event.
- R9: The shadow bank changes only through R7. Successive R8 calls reuse the last stored value, and before any R7 call they present 0 on `data_out[3:2]`.
- R10: `call_info[3]` (the A/B tag) has no effect on any output in any mode.
- R11: `data_out` changes only at the rising edge that accepts a call. Before that edge it still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_valid | input | 1 | A master call is presented |
| call_ready | output | 1 | Block can accept a call (high outside reset) |
| call_info | input | 4 | Information bits of the call; bit 3 is the A/B tag, bit 2 the bank select |
| quad_en | input | 1 | Enables 4-output banked operation |
| par_en | input | 1 | With quad_en, update both banks together |
| data_out | output | 4 | Data output ports D0..D3 (bit 0 = D0) |
| data_strobe | output | 1 | One-cycle pulse after each output event |

## Verification
The hardest case to reach is the parallel-update path where the shadow bank holds a value from an earlier call. The R8 result depends on the last upper-bank call, which may lie several calls back or come from before a mode change. The stimulus therefore sweeps every ordered pair of call values in each flag combination, with idle cycles between the pairs. It never resets between modes, so the shadow contents carry from one sweep into the next. A dedicated sequence just after reset issues a lower-bank parallel call before any upper-bank call, to show the cleared shadow.

// File: rtl/bank_out_pkg.sv
package bank_out_pkg;
  parameter int unsigned BANK_W = 2;
  localparam int unsigned OUT_W  = 2 * BANK_W;
  localparam int unsigned INFO_W = OUT_W;
  localparam int unsigned SEL_BIT = BANK_W;
  localparam int unsigned LEG_W  = OUT_W - 1;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_SPLIT  = 2'd1,
    MODE_PAR    = 2'd2
  } map_mode_e;

  function automatic map_mode_e pick_mode(input logic quad, input logic par);
    if (!quad)    return MODE_LEGACY;
    else if (par) return MODE_PAR;
    else          return MODE_SPLIT;
  endfunction
endpackage

// File: rtl/bank_call_decode.sv
module bank_call_decode
  import bank_out_pkg::*;
(
  input  logic              take,
  input  logic [LEG_W-1:0]  info_low,
  input  logic              quad_en,
  input  logic              par_en,
  input  logic [BANK_W-1:0] shadow_q,
  output logic [OUT_W-1:0]  port_we,
  output logic [OUT_W-1:0]  port_nxt,
  output logic              shadow_ld,
  output logic [BANK_W-1:0] shadow_nxt,
  output logic              evt
);
  map_mode_e mode;
  logic sel;
  logic [BANK_W-1:0] payload;

  assign mode    = pick_mode(quad_en, par_en);
  assign sel     = info_low[SEL_BIT];
  assign payload = info_low[BANK_W-1:0];
  assign shadow_nxt = payload;

  always_comb begin
    port_we   = '0;
    port_nxt  = '0;
    shadow_ld = 1'b0;
    evt       = 1'b0;
    if (take) begin
      unique case (mode)
        MODE_LEGACY: begin
          port_we[LEG_W-1:0]  = '1;
          port_nxt[LEG_W-1:0] = info_low;
          evt = 1'b1;
        end
        MODE_SPLIT: begin
          evt = 1'b1;
          if (sel) begin
            port_we[OUT_W-1:BANK_W]  = '1;
            port_nxt[OUT_W-1:BANK_W] = payload;
          end else begin
            port_we[BANK_W-1:0]  = '1;
            port_nxt[BANK_W-1:0] = payload;
          end
        end
        MODE_PAR: begin
          if (sel) begin
            shadow_ld = 1'b1;
          end else begin
            port_we  = '1;
            port_nxt = {shadow_q, payload};
            evt = 1'b1;
          end
        end
        default: begin
          port_we = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bank_shadow_reg.sv
module bank_shadow_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  AST_SHADOW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q)); // R9
endmodule

// File: rtl/bank_port_reg.sv
module bank_port_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] we,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[b] <= 1'b0;
      else if (we[b]) q[b] <= nxt[b];
    end
  end
endmodule

// File: rtl/bank_out_map.sv
module bank_out_map
  import bank_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  output logic              call_ready,
  input  logic [INFO_W-1:0] call_info,
  input  logic              quad_en,
  input  logic              par_en,
  output logic [OUT_W-1:0]  data_out,
  output logic              data_strobe
);
  logic take;
  logic [OUT_W-1:0] port_we, port_nxt;
  logic shadow_ld, evt;
  logic [BANK_W-1:0] shadow_nxt, shadow_q;
  logic unused_tag;

  assign unused_tag = call_info[INFO_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) call_ready <= 1'b0;
    else        call_ready <= 1'b1;
  end

  assign take = call_valid && call_ready;

  bank_call_decode u_dec (
    .take       (take),
    .info_low   (call_info[LEG_W-1:0]),
    .quad_en    (quad_en),
    .par_en     (par_en),
    .shadow_q   (shadow_q),
    .port_we    (port_we),
    .port_nxt   (port_nxt),
    .shadow_ld  (shadow_ld),
    .shadow_nxt (shadow_nxt),
    .evt        (evt)
  );

  bank_shadow_reg #(.W(BANK_W)) u_shadow (
    .clk (clk), .rst_n (rst_n), .ld (shadow_ld), .d (shadow_nxt), .q (shadow_q)
  );

  bank_port_reg #(.W(OUT_W)) u_ports (
    .clk (clk), .rst_n (rst_n), .we (port_we), .nxt (port_nxt), .q (data_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_strobe <= 1'b0;
    else        data_strobe <= evt;
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !call_valid |=> !data_strobe && $stable(data_out)); // R2
  AST_LEGACY_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !quad_en) |=> $stable(data_out[OUT_W-1]) && data_strobe); // R3
  AST_SPLIT_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (take && quad_en && !par_en && !call_info[SEL_BIT]) |=> $stable(data_out[OUT_W-1:BANK_W])); // R4
  AST_SPLIT_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (take && quad_en && !par_en && call_info[SEL_BIT]) |=> $stable(data_out[BANK_W-1:0])); // R5
  AST_STROBE_FROM_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe |-> $past(take)); // R6
  AST_PAR_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && quad_en && par_en && call_info[SEL_BIT]) |=> !data_strobe && $stable(data_out)); // R7
  AST_PAR_LOW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && quad_en && par_en && !call_info[SEL_BIT]) |=> data_strobe); // R8
endmodule

// File: tb/bank_out_map_tb.sv
`timescale 1ns/1ps
module bank_out_map_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_valid = 1'b0;
  logic call_ready;
  logic [3:0] call_info = '0;
  logic quad_en = 1'b0;
  logic par_en = 1'b0;
  logic [3:0] data_out;
  logic data_strobe;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_out = '0;
  logic [1:0] exp_sh = '0;
  logic exp_stb = 1'b0;

  always #2.5 clk = ~clk;

  bank_out_map u_dut (
    .clk (clk), .rst_n (rst_n), .call_valid (call_valid), .call_ready (call_ready),
    .call_info (call_info), .quad_en (quad_en), .par_en (par_en),
    .data_out (data_out), .data_strobe (data_strobe)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic v, input logic [3:0] i);
    if (!v) return "R2";
    if (!quad_en) return "R3";
    if (!par_en) return i[2] ? "R5" : "R4";
    return i[2] ? "R7" : "R8";
  endfunction

  // Called at a negedge; applies one cycle of stimulus and checks the result.
  task automatic step(input logic v, input logic [3:0] i);
    string t;
    call_valid = v;
    call_info  = i;
    #1;
    chk("R11 before edge", data_out, exp_out);
    t = tag_for(v, i);
    exp_stb = 1'b0;
    if (v) begin
      if (!quad_en) begin
        exp_out[2:0] = i[2:0];
        exp_stb = 1'b1;
      end else if (!par_en) begin
        if (i[2]) exp_out[3:2] = i[1:0];
        else      exp_out[1:0] = i[1:0];
        exp_stb = 1'b1;
      end else if (i[2]) begin
        exp_sh = i[1:0];
      end else begin
        exp_out = {exp_sh, i[1:0]};
        exp_stb = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(t, data_out, exp_out);
    chk("R6 strobe", {3'b0, data_strobe}, {3'b0, exp_stb});
  endtask

  task automatic set_mode(input logic q, input logic p);
    quad_en = q;
    par_en  = p;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out in reset", data_out, 4'h0);
    chk("R1 ready in reset", {3'b0, call_ready}, 4'h0);
    chk("R1 strobe in reset", {3'b0, data_strobe}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready", {3'b0, call_ready}, 4'h1);
    chk("R1 out after reset", data_out, 4'h0);

    // R9: cleared shadow appears on the upper bank before any store
    set_mode(1'b1, 1'b1);
    step(1'b1, 4'b0011);
    chk("R9 cleared shadow", data_out, 4'b0011);
    step(1'b1, 4'b0110);
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0001);
    step(1'b1, 4'b0010);
    chk("R9 shadow reused", data_out, 4'b1010);

    // Exhaustive ordered pairs in every flag combination, no reset between
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          step(1'b1, a[3:0]);
          step(1'b1, b[3:0]);
          step(1'b0, b[3:0] ^ 4'hF);
        end
      end
    end

    // R10: flipping only the A/B tag gives the same port value
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      for (int a = 0; a < 16; a++) begin
        logic [3:0] first;
        step(1'b1, a[3:0]);
        first = data_out;
        step(1'b1, a[3:0] ^ 4'b1000);
        chk("R10 tag ignored", data_out, first);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule